// File: doc/BRIEF.md
# Paging Access Permission Checker

This block judges one memory access against the entries of a page translation, one level at a time. A walker fetches each paging-structure entry elsewhere and hands the words over in order, from the top level down. The walker flags the final (leaf) entry. For each entry the checker tests the present bit and the reserved bits. It also folds the writeable, user and no-execute attributes into a running summary. At the leaf it settles whether the access must fault.

The leaf decision covers four kinds of rule. The first is a classic privilege lookup indexed by write protection, access mode, page ownership, page writeability and access direction. The second is a no-execute check that applies only to instruction fetches. The third is a pair of supervisor guards, one for fetches from user pages and one for data accesses to user pages. The fourth is a set of shadow-stack rules. When paging is off, a single beat yields a fixed, fault-free summary. The result is one fault flag, a 3-bit cause code and a 12-bit packed summary word, all shown for a single cycle.

Top module: `pg_perm_check`

## Requirements
- R1: An entry whose bit 0 is clear ends the walk with cause 1 (not present).
- R2: A present entry with a bit set in the reserved mask (default bits 62:52) ends the walk with cause 2 (reserved). Bit 63 also counts as reserved whenever no-execute is disabled.
- R3: Writeable (entry bit 1) and user (entry bit 2) are ANDed over every level and shown in summary bits 1 and 2. Summary bit 0 (no-execute) is set when any entry has bit 63 set and no-execute is enabled.
- R4: The privilege lookup gives cause 3 in three cases: a user access to a supervisor page, a user write to a non-writeable page, or a supervisor write to a non-writeable page. The third case applies only while write protection is on. The access kind is coded 0 read, 1 write, 2 fetch, and any other code counts as a read.
- R5: A fetch from a no-execute page gives cause 4. Reads and writes to such a page do not fault for that reason.
- R6: When supervisor-execute protection is on, a supervisor fetch from a user page gives cause 5.
- R7: When supervisor-access protection is on and the override is clear, a supervisor read or write to a user page gives cause 6. With the override set, that access is allowed.
- R8: A shadow-stack access bypasses the privilege lookup. It gives cause 7 in any of these cases: a non-leaf level is not writeable, the leaf has bit 1 set, the leaf has bit 6 (dirty) clear, or the page's user attribute differs from the access mode.
- R9: Summary bit 8 copies leaf bit 8 only while global pages are enabled. Summary bits 11:9 carry the memory type given with the leaf beat.
- R10: When paging is off, any single beat ends the walk with no fault. The summary then shows user and writeable set, no-execute clear, and memory type 6 (write-back), which gives 0xC06.
- R11: The block is ready while it walks. The cycle after the terminal beat (the leaf, a fault, or the paging-off beat), doneValid is high for exactly one cycle and ready is low. The next walk then starts from fresh accumulators.
- R12: Causes at one entry are ranked in this order: not present, reserved, shadow stack, privilege, no-execute, supervisor execute, supervisor access. The lowest-ranked cause that applies is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| entryValid | input | 1 | An entry word is offered |
| entryReady | output | 1 | The block accepts an entry this cycle |
| entryData | input | 64 | Paging-structure entry word |
| entryLeaf | input | 1 | This entry is the last level |
| entryMemType | input | 3 | Memory type for the leaf page |
| accKind | input | 2 | 0 read, 1 write, 2 fetch |
| accUser | input | 1 | Access made in user mode |
| accShadow | input | 1 | Access is a shadow-stack access |
| ctlWrProt | input | 1 | Supervisor writes honour read-only pages |
| ctlNxEn | input | 1 | No-execute bit enabled |
| ctlSupExecProt | input | 1 | Supervisor-execute protection on |
| ctlSupAccProt | input | 1 | Supervisor-access protection on |
| ctlAcOverride | input | 1 | Lifts supervisor-access protection |
| ctlGlobalEn | input | 1 | Global pages enabled |
| pagingOn | input | 1 | Translation enabled |
| doneValid | output | 1 | Result valid, one cycle |
| fault | output | 1 | The access faults |
| faultCause | output | 3 | Cause code, 0 when there is no fault |
| summary | output | 12 | Packed attribute summary |

## Verification
Several leaf rules can hit on the same beat, so the ranking of causes is what decides the result. The bench builds entries that trip two rules together. One is a supervisor fetch from a user page that is also no-execute, with supervisor-execute protection on. Another is a non-present entry that also has a reserved bit set. In each case only the higher-ranked cause must appear. A walk's terminal beat and the report of the previous walk never share a cycle, because ready drops while doneValid is high. The monitor checks this on every report.

// File: rtl/pg_perm_pkg.sv
package pg_perm_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE        = 3'd0,
    CAUSE_NOT_PRESENT = 3'd1,
    CAUSE_RESERVED    = 3'd2,
    CAUSE_PRIV        = 3'd3,
    CAUSE_NOEXEC      = 3'd4,
    CAUSE_SUP_EXEC    = 3'd5,
    CAUSE_SUP_ACCESS  = 3'd6,
    CAUSE_SHADOW      = 3'd7
  } cause_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic step;     // accept a non-terminal entry, fold attributes
    logic capture;  // accept the terminal entry, latch result
    logic clear;    // restart accumulators
  } strobe_t;

  // summary word layout
  localparam int SUM_W      = 12;
  localparam int SUM_NX     = 0;
  localparam int SUM_WR     = 1;
  localparam int SUM_USR    = 2;
  localparam int SUM_GLB    = 8;
  localparam int SUM_MT_LO  = 9;

  // entry bit positions
  localparam int ENT_P   = 0;
  localparam int ENT_RW  = 1;
  localparam int ENT_US  = 2;
  localparam int ENT_D   = 6;
  localparam int ENT_G   = 8;

endpackage

// File: rtl/pg_perm_dp.sv
module pg_perm_dp
  import pg_perm_pkg::*;
#(
  parameter int                  ENTRY_W  = 64,
  parameter logic [ENTRY_W-1:0]  RSV_MASK = 64'h7FF0_0000_0000_0000,
  parameter int                  MT_W     = 3,
  parameter logic [MT_W-1:0]     MT_WB    = 3'd6
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [ENTRY_W-1:0] entryData,
  input  logic               entryLeaf,
  input  logic [MT_W-1:0]    entryMemType,
  input  logic [1:0]         accKind,
  input  logic               accUser,
  input  logic               accShadow,
  input  logic               ctlWrProt,
  input  logic               ctlNxEn,
  input  logic               ctlSupExecProt,
  input  logic               ctlSupAccProt,
  input  logic               ctlAcOverride,
  input  logic               ctlGlobalEn,
  input  logic               pagingOn,
  output logic               terminal,
  output logic               fault,
  output logic [2:0]         faultCause,
  output logic [SUM_W-1:0]   summary
);

  localparam int NX_BIT = ENTRY_W - 1;
  localparam logic [ENTRY_W-1:0] NX_ONLY = ENTRY_W'(1) << NX_BIT;

  logic accW, accU, accNx;
  logic nextW, nextU, nextNx;
  logic isFetch, isWrite;
  logic rsvHit, shadowOk;
  logic [4:0] privIdx;
  cause_e nextCause;
  logic [SUM_W-1:0] nextSummary;

  // {write-protect, user-mode, user-page, writeable-page, is-write}
  function automatic logic privOk(input logic [4:0] idx);
    if (idx[3]) return idx[2] && (!idx[0] || idx[1]);
    return !idx[0] || idx[1] || !idx[4];
  endfunction

  always_comb begin
    isFetch  = (accKind == ACC_FETCH);
    isWrite  = (accKind == ACC_WRITE);
    rsvHit   = |(entryData & (RSV_MASK | (ctlNxEn ? '0 : NX_ONLY)));
    nextW    = accW & entryData[ENT_RW];
    nextU    = accU & entryData[ENT_US];
    nextNx   = accNx | (ctlNxEn & entryData[NX_BIT]);
    privIdx  = {ctlWrProt, accUser, nextU, nextW, isWrite};
    shadowOk = accW && !entryData[ENT_RW] && entryData[ENT_D] && (nextU == accUser);
    terminal = !pagingOn || !entryData[ENT_P] || rsvHit || entryLeaf;
  end

  // ranked fault decision for the current entry
  always_comb begin
    nextCause = CAUSE_NONE;
    if (!pagingOn)                   nextCause = CAUSE_NONE;
    else if (!entryData[ENT_P])      nextCause = CAUSE_NOT_PRESENT;
    else if (rsvHit)                 nextCause = CAUSE_RESERVED;
    else if (entryLeaf) begin
      if (accShadow && !shadowOk)                  nextCause = CAUSE_SHADOW;
      else if (!accShadow && !privOk(privIdx))     nextCause = CAUSE_PRIV;
      else if (!accShadow && nextNx && isFetch)    nextCause = CAUSE_NOEXEC;
      else if (ctlSupExecProt && isFetch && !accUser && nextU)
                                                   nextCause = CAUSE_SUP_EXEC;
      else if (ctlSupAccProt && !ctlAcOverride && !isFetch && !accUser && nextU)
                                                   nextCause = CAUSE_SUP_ACCESS;
    end
  end

  always_comb begin
    nextSummary = '0;
    if (!pagingOn) begin
      nextSummary[SUM_WR]  = 1'b1;
      nextSummary[SUM_USR] = 1'b1;
      nextSummary[SUM_MT_LO +: MT_W] = MT_WB;
    end else begin
      nextSummary[SUM_NX]  = nextNx;
      nextSummary[SUM_WR]  = nextW;
      nextSummary[SUM_USR] = nextU;
      nextSummary[SUM_GLB] = ctlGlobalEn & entryData[ENT_G];
      nextSummary[SUM_MT_LO +: MT_W] = entryMemType;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      accW  <= 1'b1;
      accU  <= 1'b1;
      accNx <= 1'b0;
    end else if (stb.step) begin
      accW  <= nextW;
      accU  <= nextU;
      accNx <= nextNx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fault      <= 1'b0;
      faultCause <= CAUSE_NONE;
      summary    <= '0;
    end else if (stb.capture) begin
      fault      <= (nextCause != CAUSE_NONE);
      faultCause <= nextCause;
      summary    <= nextSummary;
    end
  end

endmodule

// File: rtl/pg_perm_ctl.sv
module pg_perm_ctl
  import pg_perm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    entryValid,
  input  logic    terminal,
  output logic    entryReady,
  output logic    doneValid,
  output strobe_t stb
);

  typedef enum logic {ST_WALK, ST_REPORT} state_e;
  state_e state;
  logic   accept;

  always_comb begin
    entryReady  = (state == ST_WALK);
    doneValid   = (state == ST_REPORT);
    accept      = entryValid && entryReady;
    stb.step    = accept && !terminal;
    stb.capture = accept && terminal;
    stb.clear   = (state == ST_REPORT);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                state <= ST_WALK;
    else if (stb.capture)     state <= ST_REPORT;
    else if (state == ST_REPORT) state <= ST_WALK;
  end

endmodule

// File: rtl/pg_perm_check.sv
module pg_perm_check
  import pg_perm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        entryValid,
  output logic        entryReady,
  input  logic [63:0] entryData,
  input  logic        entryLeaf,
  input  logic [2:0]  entryMemType,
  input  logic [1:0]  accKind,
  input  logic        accUser,
  input  logic        accShadow,
  input  logic        ctlWrProt,
  input  logic        ctlNxEn,
  input  logic        ctlSupExecProt,
  input  logic        ctlSupAccProt,
  input  logic        ctlAcOverride,
  input  logic        ctlGlobalEn,
  input  logic        pagingOn,
  output logic        doneValid,
  output logic        fault,
  output logic [2:0]  faultCause,
  output logic [11:0] summary
);

  strobe_t stb;
  logic    terminal;

  pg_perm_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .entryValid (entryValid),
    .terminal   (terminal),
    .entryReady (entryReady),
    .doneValid  (doneValid),
    .stb        (stb)
  );

  pg_perm_dp #(
    .ENTRY_W (64),
    .MT_W    (3)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .entryData      (entryData),
    .entryLeaf      (entryLeaf),
    .entryMemType   (entryMemType),
    .accKind        (accKind),
    .accUser        (accUser),
    .accShadow      (accShadow),
    .ctlWrProt      (ctlWrProt),
    .ctlNxEn        (ctlNxEn),
    .ctlSupExecProt (ctlSupExecProt),
    .ctlSupAccProt  (ctlSupAccProt),
    .ctlAcOverride  (ctlAcOverride),
    .ctlGlobalEn    (ctlGlobalEn),
    .pagingOn       (pagingOn),
    .terminal       (terminal),
    .fault          (fault),
    .faultCause     (faultCause),
    .summary        (summary)
  );

endmodule

// File: rtl/pg_perm_chk.sv
module pg_perm_chk #(
  parameter logic [63:0] RSV_MASK = 64'h7FF0_0000_0000_0000
) (
  input logic        clk,
  input logic        rstN,
  input logic        entryValid,
  input logic        entryReady,
  input logic [63:0] entryData,
  input logic        ctlGlobalEn,
  input logic        pagingOn,
  input logic        doneValid,
  input logic        fault,
  input logic [2:0]  faultCause,
  input logic [11:0] summary
);

  logic accept;
  assign accept = entryValid && entryReady;

  // R1: absent entry ends the walk with cause 1
  a_r1_not_present: assert property (@(posedge clk) disable iff (!rstN)
    (accept && pagingOn && !entryData[0]) |=> (doneValid && fault && faultCause == 3'd1));

  // R2: present entry with reserved bit set ends with cause 2
  a_r2_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (accept && pagingOn && entryData[0] && (|(entryData & RSV_MASK)))
      |=> (doneValid && fault && faultCause == 3'd2));

  // R10: paging off gives the fixed fault-free summary
  a_r10_paging_off: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !pagingOn) |=> (doneValid && !fault && summary == 12'hC06));

  // R9: global bit never shown while global pages are disabled
  a_r9_global_gated: assert property (@(posedge clk) disable iff (!rstN)
    (accept && pagingOn && !ctlGlobalEn) |=> !(doneValid && summary[8]));

  // R11: report lasts one cycle
  a_r11_single_report: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R11: no entry accepted while reporting
  a_r11_stall: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !entryReady);

endmodule

bind pg_perm_check pg_perm_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .entryValid  (entryValid),
  .entryReady  (entryReady),
  .entryData   (entryData),
  .ctlGlobalEn (ctlGlobalEn),
  .pagingOn    (pagingOn),
  .doneValid   (doneValid),
  .fault       (fault),
  .faultCause  (faultCause),
  .summary     (summary)
);

// File: tb/tb_pg_perm_check.sv
`timescale 1ns/1ps
module tb_pg_perm_check;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        entryValid = 1'b0;
  logic        entryReady;
  logic [63:0] entryData = '0;
  logic        entryLeaf = 1'b0;
  logic [2:0]  entryMemType = '0;
  logic [1:0]  accKind = 2'd0;
  logic        accUser = 1'b1;
  logic        accShadow = 1'b0;
  logic        ctlWrProt = 1'b0;
  logic        ctlNxEn = 1'b1;
  logic        ctlSupExecProt = 1'b0;
  logic        ctlSupAccProt = 1'b0;
  logic        ctlAcOverride = 1'b0;
  logic        ctlGlobalEn = 1'b0;
  logic        pagingOn = 1'b1;
  logic        doneValid;
  logic        fault;
  logic [2:0]  faultCause;
  logic [11:0] summary;

  always #5 clk = ~clk;

  pg_perm_check dut (.*);

  localparam logic [63:0] P  = 64'h1;
  localparam logic [63:0] W  = 64'h2;
  localparam logic [63:0] U  = 64'h4;
  localparam logic [63:0] D  = 64'h40;
  localparam logic [63:0] G  = 64'h100;
  localparam logic [63:0] NX = 64'h8000_0000_0000_0000;
  localparam logic [63:0] RV = 64'h0080_0000_0000_0000;
  localparam logic [63:0] PWU = P | W | U;

  typedef struct {
    logic [2:0]  cause;
    logic [11:0] sum;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic beat(input logic [63:0] d, input logic leaf, input logic [2:0] mt);
    entryValid   = 1'b1;
    entryData    = d;
    entryLeaf    = leaf;
    entryMemType = mt;
    @(negedge clk);
    while (!entryReady) @(negedge clk);
    @(posedge clk);
    #1 entryValid = 1'b0;
  endtask

  task automatic walk(input int n, input logic [63:0] e0, input logic [63:0] e1,
                      input logic [63:0] e2, input logic [63:0] e3,
                      input logic leafLast, input logic [2:0] mt,
                      input logic [2:0] expCause, input logic [11:0] expSum,
                      input string tag);
    logic [63:0] ents [4];
    exp_t it;
    ents[0] = e0; ents[1] = e1; ents[2] = e2; ents[3] = e3;
    it.cause = expCause; it.sum = expSum; it.tag = tag;
    expQ.push_back(it);
    for (int i = 0; i < n; i++)
      beat(ents[i], (i == n-1) ? leafLast : 1'b0, mt);
    repeat (2) @(posedge clk);
    #1;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && doneValid) begin
      exp_t it;
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 unexpected report: actual cause=%0d expected none", faultCause);
      end else begin
        it = expQ.pop_front();
        checks++;
        if (faultCause !== it.cause || fault !== (it.cause != 3'd0)) begin
          fails++;
          $display("FAIL %s cause: actual %0d/%0b expected %0d", it.tag, faultCause, fault, it.cause);
        end
        if (it.cause == 3'd0) begin
          checks++;
          if (summary !== it.sum) begin
            fails++;
            $display("FAIL %s summary: actual %h expected %h", it.tag, summary, it.sum);
          end
        end
      end
      checks++;
      if (entryReady !== 1'b0) begin
        fails++;
        $display("FAIL R11 ready during report: actual %b expected 0", entryReady);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (entryReady !== 1'b1 || doneValid !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset state: actual ready=%b done=%b expected 1/0", entryReady, doneValid);
    end
    @(posedge clk); #1;

    // R3 full walk and AND folding
    walk(4, PWU, PWU, PWU, PWU, 1, 3'd3, 3'd0, 12'h606, "R3 all-permissive");
    walk(4, PWU, P|U, PWU, PWU, 1, 3'd0, 3'd0, 12'h004, "R3 mid not writeable");
    // R4 privilege lookup
    accKind = 2'd1;
    walk(4, PWU, P|U, PWU, PWU, 1, 3'd0, 3'd3, 12'h0, "R4 user write readonly");
    accUser = 1'b0;
    walk(2, PWU, P, 0, 0, 1, 3'd0, 3'd0, 12'h000, "R4 sup write wp clear");
    ctlWrProt = 1'b1;
    walk(2, PWU, P, 0, 0, 1, 3'd0, 3'd3, 12'h0, "R4 sup write wp set");
    ctlWrProt = 1'b0; accUser = 1'b1; accKind = 2'd0;
    walk(2, PWU, P|W, 0, 0, 1, 3'd0, 3'd3, 12'h0, "R4 user read sup page");
    // R1, R2, R12
    walk(2, PWU, W|U, 0, 0, 0, 3'd0, 3'd1, 12'h0, "R1 not present level 2");
    walk(1, PWU|RV, 0, 0, 0, 0, 3'd0, 3'd2, 12'h0, "R2 reserved bit 55");
    ctlNxEn = 1'b0;
    walk(1, PWU|NX, 0, 0, 0, 0, 3'd0, 3'd2, 12'h0, "R2 bit63 nx disabled");
    ctlNxEn = 1'b1;
    walk(1, W|U|RV, 0, 0, 0, 0, 3'd0, 3'd1, 12'h0, "R12 absent beats reserved");
    // R5
    accKind = 2'd2;
    walk(2, PWU|NX, PWU, 0, 0, 1, 3'd0, 3'd4, 12'h0, "R5 fetch nx");
    accKind = 2'd0;
    walk(2, PWU|NX, PWU, 0, 0, 1, 3'd0, 3'd0, 12'h007, "R5 read nx page");
    // R6, R12
    ctlSupExecProt = 1'b1; accUser = 1'b0; accKind = 2'd2;
    walk(2, PWU, PWU, 0, 0, 1, 3'd0, 3'd5, 12'h0, "R6 sup fetch user page");
    walk(2, PWU, PWU|NX, 0, 0, 1, 3'd0, 3'd4, 12'h0, "R12 nx beats sup exec");
    ctlSupExecProt = 1'b0;
    // R7
    ctlSupAccProt = 1'b1; accKind = 2'd0;
    walk(2, PWU, PWU, 0, 0, 1, 3'd0, 3'd6, 12'h0, "R7 sup read user page");
    ctlAcOverride = 1'b1;
    walk(2, PWU, PWU, 0, 0, 1, 3'd0, 3'd0, 12'h006, "R7 override set");
    ctlAcOverride = 1'b0; accKind = 2'd2;
    walk(2, PWU, PWU, 0, 0, 1, 3'd0, 3'd0, 12'h006, "R7 fetch exempt");
    ctlSupAccProt = 1'b0;
    // R8 shadow stack
    accShadow = 1'b1; accKind = 2'd1; accUser = 1'b1;
    walk(3, PWU, PWU, P|U|D, 0, 1, 3'd0, 3'd0, 12'h004, "R8 user shadow ok");
    walk(3, PWU, PWU, PWU|D, 0, 1, 3'd0, 3'd7, 12'h0, "R8 leaf writeable");
    walk(3, PWU, PWU, P|U, 0, 1, 3'd0, 3'd7, 12'h0, "R8 leaf not dirty");
    walk(3, PWU, P|U, P|U|D, 0, 1, 3'd0, 3'd7, 12'h0, "R8 upper readonly");
    accUser = 1'b0;
    walk(3, PWU, PWU, P|U|D, 0, 1, 3'd0, 3'd7, 12'h0, "R8 mode mismatch");
    walk(3, P|W, P|W, P|D, 0, 1, 3'd0, 3'd0, 12'h000, "R8 sup shadow ok");
    accShadow = 1'b0; accKind = 2'd0; accUser = 1'b1;
    // R9
    ctlGlobalEn = 1'b1;
    walk(2, PWU, PWU|G, 0, 0, 1, 3'd5, 3'd0, 12'hB06, "R9 global on");
    ctlGlobalEn = 1'b0;
    walk(2, PWU, PWU|G, 0, 0, 1, 3'd5, 3'd0, 12'hA06, "R9 global off");
    // R10
    pagingOn = 1'b0;
    walk(1, 64'h0, 0, 0, 0, 0, 3'd1, 3'd0, 12'hC06, "R10 paging off");
    pagingOn = 1'b1;

    repeat (4) @(posedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R11 missing reports: actual %0d pending expected 0", expQ.size());
    end
    finished = 1'b1;
    report();
  end

endmodule